// File: doc/BRIEF.md
# Boot-Selectable Memory Map Decoder

This block turns a 24-bit physical address into one of three select lines: internal flash, on-chip RAM or external memory. Every address asserts exactly one of the three. The decode is combinational from the lookup address and a small registered configuration.

The configuration holds three bits. The first is the flash enable. It is loaded from a boot-select pin while reset is held, so a board strap chooses whether the first fetches come from flash or from external memory. Software may then rewrite the configuration. It can turn the flash on, move the low 32 KB flash window between segment 0 and segment 1, and open or close the flash range above segment 0.

An end-of-initialisation event locks the configuration until the next reset. Whenever the enable bit or the window bit changes value, a one-cycle pulse is raised, so that a downstream unit can reload its address pointers.

Top module: `memmap_decoder`

## Requirements
- R1: While `rst_n` is low, `cfg_o[0]` (flash enable) follows `boot_flash_i`. On release `cfg_o[1]` (low window in segment 0) is 1 and `cfg_o[2]` (segment restrict) is 1.
- R2: With enable=1 and window bit=1, addresses 00'0000h–00'7FFFh select flash.
- R3: With enable=0, every address outside the RAM window selects external memory, including the vector area 00'0000h–00'01FFh.
- R4: A write with `cfg_we_i`=1 while unlocked loads `cfg_wdata_i` into the configuration at the next rising edge. Bit 0 is enable, bit 1 is window, bit 2 is restrict.
- R5: With enable=1, window bit=0 and restrict=0, addresses 01'0000h–01'7FFFh select flash, and 00'0000h–00'7FFFh select external memory.
- R6: With enable=1 and restrict=0, addresses 01'8000h–08'FFFFh select flash whatever the window bit is.
- R7: After a cycle with `einit_i`=1 (that cycle included), writes are ignored until reset.
- R8: With restrict=1, no address at or above 01'0000h selects flash.
- R9: Addresses 00'F000h–00'FFFFh select RAM in every configuration.
- R10: Exactly one of `sel_flash_o`, `sel_ram_o`, `sel_ext_o` is high for every address.
- R11: `remap_chg_o` is high for exactly the one cycle after an accepted write that changes bit 0 or bit 1. A write that changes only bit 2, or changes nothing, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_flash_i | input | 1 | Boot-select strap, sampled during reset |
| einit_i | input | 1 | End-of-initialisation event, locks configuration |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Configuration write data {restrict, window, enable} |
| addr_i | input | 24 | Lookup address |
| sel_flash_o | output | 1 | Address decodes to internal flash |
| sel_ram_o | output | 1 | Address decodes to on-chip RAM |
| sel_ext_o | output | 1 | Address decodes to external memory |
| cfg_o | output | 3 | Current configuration {restrict, window, enable} |
| remap_chg_o | output | 1 | One-cycle pulse after enable or window change |

## Verification
The decode is swept over the full 24-bit space in 2 KB strides with a moving low offset. The sweep is repeated in all eight configurations and again after lock. The strides tell whether region edges sit at the right segment, and the offsets catch low-bit comparison slips.

A fixed list of addresses on each side of every boundary separates off-by-one errors at the window, RAM and upper-range limits.

Both strap levels are applied through reset to show that the enable comes from the pin. Writes that change each bit on its own show which changes must raise the pulse and which must not.

// File: rtl/memmap_pkg.sv
// Package: shared configuration type for the memory map decoder.
// Assumes bit order {restrict, window, enable} is visible to software.
package memmap_pkg;

    typedef struct packed {
        logic seg_restrict;   // 1: flash reachable only in segment 0
        logic win_low;        // 1: low flash window in segment 0, 0: in segment 1
        logic flash_en;       // 1: flash decoded at all
    } map_cfg_t;

    localparam int CFG_W = $bits(map_cfg_t);

endpackage

// File: rtl/memmap_cfg_regs.sv
// Module: configuration register with boot strap sampling and lock.
// Assumes a synchronous active-low reset that lasts at least one clock
// edge, and that einit_i is a level or pulse from the sequencer.
module memmap_cfg_regs
    import memmap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     boot_flash_i,
    input  logic     einit_i,
    input  logic     we_i,
    input  map_cfg_t wdata_i,
    output map_cfg_t cfg_o,
    output logic     chg_o
);

    map_cfg_t cfg_q;
    logic     locked_q;
    logic     wr_ok;
    logic     map_bits_differ;

    // Accept a write only while unlocked and not in the locking cycle.
    assign wr_ok           = we_i && !locked_q && !einit_i;
    assign map_bits_differ = (wdata_i.flash_en != cfg_q.flash_en) ||
                             (wdata_i.win_low  != cfg_q.win_low);

    // Configuration storage: strap loads enable during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.flash_en     <= boot_flash_i;
            cfg_q.win_low      <= 1'b1;
            cfg_q.seg_restrict <= 1'b1;
        end else if (wr_ok) begin
            cfg_q <= wdata_i;
        end
    end

    // Sticky lock set by the end-of-initialisation event.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (einit_i) locked_q <= 1'b1;
    end

    // One-cycle pulse when enable or window changes.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_o <= 1'b0;
        else        chg_o <= wr_ok && map_bits_differ;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/memmap_region_decode.sv
// Module: combinational address-to-region decode.
// Assumes the RAM window does not need to avoid flash ranges: it wins.
module memmap_region_decode
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SEG_BYTES = 32'h1_0000,
    parameter int WIN_BYTES = 32'h8000,
    parameter int RAM_BASE  = 32'h00_F000,
    parameter int RAM_BYTES = 32'h1000,
    parameter int HI_BASE   = 32'h01_8000,
    parameter int HI_LAST   = 32'h08_FFFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  map_cfg_t          cfg_i,
    output logic              sel_flash_o,
    output logic              sel_ram_o,
    output logic              sel_ext_o
);

    localparam logic [ADDR_W-1:0] WIN0_LAST = ADDR_W'(WIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] WIN1_BASE = ADDR_W'(SEG_BYTES);
    localparam logic [ADDR_W-1:0] WIN1_LAST = ADDR_W'(SEG_BYTES + WIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] RAM_LO    = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] RAM_HI    = ADDR_W'(RAM_BASE + RAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] HI_LO     = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_HI     = ADDR_W'(HI_LAST);

    logic in_ram, in_win0, in_win1, in_hi, flash_hit;

    // Range compares against the fixed map.
    always_comb begin
        in_ram  = (addr_i >= RAM_LO)    && (addr_i <= RAM_HI);
        in_win0 = (addr_i <= WIN0_LAST);
        in_win1 = (addr_i >= WIN1_BASE) && (addr_i <= WIN1_LAST);
        in_hi   = (addr_i >= HI_LO)     && (addr_i <= HI_HI);
    end

    // Flash hit from the configuration: window placement and restriction.
    always_comb begin
        flash_hit = 1'b0;
        if (cfg_i.flash_en) begin
            if (cfg_i.win_low && in_win0)
                flash_hit = 1'b1;
            if (!cfg_i.seg_restrict && !cfg_i.win_low && in_win1)
                flash_hit = 1'b1;
            if (!cfg_i.seg_restrict && in_hi)
                flash_hit = 1'b1;
        end
    end

    // Priority: RAM, then flash, then external.
    always_comb begin
        sel_ram_o   = in_ram;
        sel_flash_o = !in_ram && flash_hit;
        sel_ext_o   = !in_ram && !flash_hit;
    end

endmodule

// File: rtl/memmap_decoder.sv
// Module: top of the boot-selectable memory map decoder.
// Assumes addr_i is stable for the lookup; outputs are combinational.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SEG_BYTES = 32'h1_0000,
    parameter int WIN_BYTES = 32'h8000,
    parameter int RAM_BASE  = 32'h00_F000,
    parameter int RAM_BYTES = 32'h1000,
    parameter int HI_BASE   = 32'h01_8000,
    parameter int HI_LAST   = 32'h08_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_flash_i,
    input  logic              einit_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_wdata_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sel_flash_o,
    output logic              sel_ram_o,
    output logic              sel_ext_o,
    output logic [2:0]        cfg_o,
    output logic              remap_chg_o
);

    map_cfg_t cfg;

    memmap_cfg_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_flash_i (boot_flash_i),
        .einit_i      (einit_i),
        .we_i         (cfg_we_i),
        .wdata_i      (map_cfg_t'(cfg_wdata_i)),
        .cfg_o        (cfg),
        .chg_o        (remap_chg_o)
    );

    memmap_region_decode #(
        .ADDR_W    (ADDR_W),
        .SEG_BYTES (SEG_BYTES),
        .WIN_BYTES (WIN_BYTES),
        .RAM_BASE  (RAM_BASE),
        .RAM_BYTES (RAM_BYTES),
        .HI_BASE   (HI_BASE),
        .HI_LAST   (HI_LAST)
    ) u_dec (
        .addr_i      (addr_i),
        .cfg_i       (cfg),
        .sel_flash_o (sel_flash_o),
        .sel_ram_o   (sel_ram_o),
        .sel_ext_o   (sel_ext_o)
    );

    assign cfg_o = cfg_w'(cfg);

    localparam int cfg_w = CFG_W;

endmodule

// File: rtl/memmap_decoder_chk.sv
// Module: property checker for memmap_decoder, attached by bind.
// Assumes default map parameters match the top's.
module memmap_decoder_chk #(
    parameter int ADDR_W    = 24,
    parameter int SEG_BYTES = 32'h1_0000,
    parameter int RAM_BASE  = 32'h00_F000,
    parameter int RAM_BYTES = 32'h1000,
    parameter int HI_BASE   = 32'h01_8000,
    parameter int HI_LAST   = 32'h08_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              einit_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              sel_flash_o,
    input logic              sel_ram_o,
    input logic              sel_ext_o,
    input logic [2:0]        cfg_o,
    input logic              remap_chg_o
);

    localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE + RAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] SEG1   = ADDR_W'(SEG_BYTES);
    localparam logic [ADDR_W-1:0] HI_LO  = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_HI  = ADDR_W'(HI_LAST);

    logic locked_seen;

    // Tracks that the lock event has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_seen <= 1'b0;
        else if (einit_i) locked_seen <= 1'b1;
    end

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_flash_o, sel_ram_o, sel_ext_o}) == 1);

    p_ram_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= RAM_LO && addr_i <= RAM_HI) |-> sel_ram_o);

    p_off_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_o[0] |-> !sel_flash_o);

    p_hi_flash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[0] && !cfg_o[2] && addr_i >= HI_LO && addr_i <= HI_HI) |-> sel_flash_o);

    p_restrict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[2] && addr_i >= SEG1) |-> !sel_flash_o);

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_seen || einit_i) |=> $stable(cfg_o));

    p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        remap_chg_o |-> (cfg_o[1:0] != $past(cfg_o[1:0])));

endmodule

bind memmap_decoder memmap_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .SEG_BYTES (SEG_BYTES),
    .RAM_BASE  (RAM_BASE),
    .RAM_BYTES (RAM_BYTES),
    .HI_BASE   (HI_BASE),
    .HI_LAST   (HI_LAST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .einit_i     (einit_i),
    .addr_i      (addr_i),
    .sel_flash_o (sel_flash_o),
    .sel_ram_o   (sel_ram_o),
    .sel_ext_o   (sel_ext_o),
    .cfg_o       (cfg_o),
    .remap_chg_o (remap_chg_o)
);

// File: tb/memmap_decoder_tb.sv
// Bench: sweeps the decode in every configuration, checks strap, lock, pulse.
module memmap_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_flash_i = 1'b1;
    logic        einit_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_wdata_i = 3'b000;
    logic [23:0] addr_i = 24'h0;
    logic        sel_flash_o, sel_ram_o, sel_ext_o, remap_chg_o;
    logic [2:0]  cfg_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    memmap_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_flash_i (boot_flash_i),
        .einit_i      (einit_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .addr_i       (addr_i),
        .sel_flash_o  (sel_flash_o),
        .sel_ram_o    (sel_ram_o),
        .sel_ext_o    (sel_ext_o),
        .cfg_o        (cfg_o),
        .remap_chg_o  (remap_chg_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compares one value and reports a mismatch.
    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected {flash, ram, ext} computed from the requirements.
    function automatic logic [2:0] model(input logic [2:0] c, input logic [23:0] a);
        logic ram, fl;
        ram = (a >= 24'h00F000) && (a <= 24'h00FFFF);
        fl  = c[0] && ((c[1] && a <= 24'h007FFF) ||
                       (!c[2] && !c[1] && a >= 24'h010000 && a <= 24'h017FFF) ||
                       (!c[2] && a >= 24'h018000 && a <= 24'h08FFFF));
        return {!ram && fl, ram, !ram && !fl};
    endfunction

    // Checks one address against the model, tagging the requirement.
    task automatic probe(input logic [23:0] a, input string req);
        addr_i = a;
        #1;
        check(req, {21'd0, sel_flash_o, sel_ram_o, sel_ext_o}, {21'd0, model(cfg_o, a)});
    endtask

    // Sweeps the whole space plus boundary addresses.
    task automatic sweep(input string req);
        logic [23:0] edges [13] = '{24'h0, 24'h1FF, 24'h7FFF, 24'h8000, 24'hEFFF,
                                    24'hF000, 24'hFFFF, 24'h10000, 24'h17FFF,
                                    24'h18000, 24'h8FFFF, 24'h90000, 24'hFFFFFF};
        for (int i = 0; i < 8192; i++)
            probe(24'(i * 32'h800 + (i % 7) * 32'h13B), req);
        foreach (edges[k]) probe(edges[k], req);
    endtask

    // Issues one configuration write and returns after the capturing edge.
    task automatic write_cfg(input logic [2:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    initial begin
        // R1: strap low, enable cleared.
        boot_flash_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {21'd0, cfg_o}, 24'h6);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {21'd0, cfg_o}, 24'h6);
        check("R1", {23'd0, remap_chg_o}, 24'h0);
        // R3: flash off, all external except RAM.
        sweep("R3");
        probe(24'h0, "R3");
        probe(24'h1FF, "R3");

        // R1: strap high, default map.
        rst_n = 1'b0;
        boot_flash_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {21'd0, cfg_o}, 24'h7);
        probe(24'h0, "R2");
        check("R2", {23'd0, sel_flash_o}, 24'h1);
        sweep("R2");

        // R4/R5/R6/R8/R9/R10: every configuration.
        for (int c = 0; c < 8; c++) begin
            write_cfg(3'(c));
            check("R4", {21'd0, cfg_o}, 24'(c));
            sweep(c == 1 ? "R5" : (c[2] ? "R8" : "R6"));
        end
        probe(24'h010000, "R5");
        probe(24'h00F800, "R9");

        // R11: pulse rules.
        write_cfg(3'b011);
        write_cfg(3'b001);
        check("R11 window change", {23'd0, remap_chg_o}, 24'h1);
        @(negedge clk);
        check("R11 single cycle", {23'd0, remap_chg_o}, 24'h0);
        write_cfg(3'b101);
        check("R11 restrict only", {23'd0, remap_chg_o}, 24'h0);
        write_cfg(3'b101);
        check("R11 no change", {23'd0, remap_chg_o}, 24'h0);
        write_cfg(3'b100);
        check("R11 enable change", {23'd0, remap_chg_o}, 24'h1);
        write_cfg(3'b001);

        // R7: lock, including a write in the same cycle as the event.
        @(negedge clk);
        einit_i = 1'b1;
        cfg_we_i = 1'b1;
        cfg_wdata_i = 3'b110;
        @(negedge clk);
        einit_i = 1'b0;
        cfg_we_i = 1'b0;
        check("R7 same cycle", {21'd0, cfg_o}, 24'h1);
        write_cfg(3'b010);
        check("R7 after lock", {21'd0, cfg_o}, 24'h1);
        check("R7 no pulse", {23'd0, remap_chg_o}, 24'h0);
        sweep("R7");
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int t = 0; t < 190000 && !done; t++) @(negedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule